// File: doc/BRIEF.md
# Radar Chirp Timing Sequencer

This block paces the receive side of a pulsed radar. Each chirp cycle has five phases in a fixed order: long chirp, long listen, guard, short chirp and short listen. The length of each phase, in clock cycles, comes from a 16-bit value that software can change at runtime. A registered select line tells the downstream matched filter which reference (long or short) applies. At the start of every cycle a one-cycle chirp strobe is raised.

Three nested counters track position in the scan:
- The chirp count runs up to a runtime limit.
- The elevation count runs up to the `ELEV_STEPS` parameter.
- The azimuth count runs up to the `AZ_STEPS` parameter.

Each wrap resets the lower count, raises a one-cycle strobe and advances the next counter up. The wrap of the azimuth count marks the end of a full scan.

A 2-bit mode selects the source of sequencing:
- **External (00):** strobes driven from outside are passed through.
- **Free-running scan (01):** chirp cycles run back to back.
- **Single shot (10):** one chirp cycle runs per trigger pulse.

Inputs are assumed to be already synchronous to `clk`.

Top module: `chirp_sequencer`

## Requirements
- R1: While `rst` is high and in the first cycle after it, every output is 0: strobes, counters, `long_sel`, `scanning` and `scan_done`.
- R2: With `mode`=00, a high level on `ext_chirp`, `ext_elev` or `ext_azim` appears on `chirp_stb`, `elev_stb` or `azim_stb` one clock later. In this mode no chirp cycle runs, `trig` is ignored and the counters hold.
- R3: A chirp cycle runs its phases in this order: long chirp (`cfg_long_tx`), long listen (`cfg_long_rx`), guard (`cfg_guard`), short chirp (`cfg_short_tx`), short listen (`cfg_short_rx`). Each phase lasts exactly its configured number of cycles. `long_sel` is high during the first two phases only, and `scanning` is high for the whole cycle.
- R4: A configured duration of 0 makes that phase last exactly one cycle.
- R5: With `mode`=10 and the block idle, a one-cycle `trig` pulse starts exactly one chirp cycle, after which the block goes idle. A `trig` pulse while a cycle is in progress has no effect.
- R6: Each generated chirp cycle raises `chirp_stb` for one clock, in its first long-chirp cycle.
- R7: When the short listen phase of a chirp cycle ends, `chirp_cnt` advances by one. When the advanced value would reach `cfg_chirps_per_elev` (0 acts as 1), `chirp_cnt` becomes 0 instead, `elev_stb` pulses for one cycle and `elev_cnt` advances. `elev_stb` and the counter update appear in the cycle after the last short listen cycle.
- R8: When `elev_cnt` would reach `ELEV_STEPS`, it becomes 0 and `azim_stb` pulses while `azim_cnt` advances. When `azim_cnt` would reach `AZ_STEPS`, it becomes 0 and `scan_done` pulses. These strobes all coincide with `elev_stb` in the same cycle.
- R9: With `mode`=01, chirp cycles follow one another with no idle cycle between them. The first starts on the clock after the mode is set.
- R10: Changing `mode` to 00 or 11 during a chirp cycle returns the block to idle on the next clock (`scanning` low), and the interrupted cycle does not advance `chirp_cnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 00 external, 01 free-running scan, 10 single shot, 11 idle |
| trig | input | 1 | Single-shot start pulse |
| ext_chirp | input | 1 | External new-chirp strobe |
| ext_elev | input | 1 | External new-elevation strobe |
| ext_azim | input | 1 | External new-azimuth strobe |
| cfg_long_tx | input | 16 | Long chirp length in cycles |
| cfg_long_rx | input | 16 | Long listen length in cycles |
| cfg_guard | input | 16 | Guard length in cycles |
| cfg_short_tx | input | 16 | Short chirp length in cycles |
| cfg_short_rx | input | 16 | Short listen length in cycles |
| cfg_chirps_per_elev | input | 6 | Chirps per elevation step |
| long_sel | output | 1 | High while the long reference applies |
| chirp_stb | output | 1 | New-chirp strobe |
| elev_stb | output | 1 | New-elevation strobe |
| azim_stb | output | 1 | New-azimuth strobe |
| chirp_cnt | output | 6 | Chirp index within elevation step |
| elev_cnt | output | 6 | Elevation index |
| azim_cnt | output | 6 | Azimuth index |
| scanning | output | 1 | A chirp cycle is in progress |
| scan_done | output | 1 | One-cycle pulse at the end of a full scan |

## Verification
The end of one chirp cycle and the start of the next fall on the same clock in free-running mode. At a scan boundary that clock also carries `elev_stb`, `azim_stb` and `scan_done`. The bench makes this happen with unit phase lengths and small elevation and azimuth limits, so a full scan takes only a few dozen cycles. It then checks, at the `scan_done` cycle, that the next `chirp_stb` is present together with both higher strobes and that all three counters read zero. A separate case drops the mode to external in the last short listen cycle, so that the abort and the counter advance compete for the same edge. That case expects the advance to be lost.

// File: rtl/chirp_seq_pkg.sv
package chirp_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_LTX   = 3'd1,
    PH_LRX   = 3'd2,
    PH_GUARD = 3'd3,
    PH_STX   = 3'd4,
    PH_SRX   = 3'd5
  } phase_t;

  localparam logic [1:0] MODE_EXT  = 2'b00;
  localparam logic [1:0] MODE_AUTO = 2'b01;
  localparam logic [1:0] MODE_ONE  = 2'b10;

  // chirp, elevation, azimuth
  localparam int NUM_LEVELS = 3;

endpackage

// File: rtl/chirp_phase_fsm.sv
module chirp_phase_fsm
  import chirp_seq_pkg::*;
#(
  parameter int DUR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic             trig,
  input  logic [DUR_W-1:0] cfg_long_tx,
  input  logic [DUR_W-1:0] cfg_long_rx,
  input  logic [DUR_W-1:0] cfg_guard,
  input  logic [DUR_W-1:0] cfg_short_tx,
  input  logic [DUR_W-1:0] cfg_short_rx,
  output logic             start_stb,
  output logic             long_sel,
  output logic             busy,
  output logic             cycle_end
);

  phase_t           st, nx;
  logic [DUR_W-1:0] tmr, raw, ld;
  logic             abort, last;

  assign abort = (mode == MODE_EXT) || (mode == 2'b11);
  assign last  = (tmr == '0);

  always_comb begin
    nx = st;
    unique case (st)
      PH_IDLE:  if (mode == MODE_AUTO || (mode == MODE_ONE && trig)) nx = PH_LTX;
      PH_LTX:   if (last) nx = PH_LRX;
      PH_LRX:   if (last) nx = PH_GUARD;
      PH_GUARD: if (last) nx = PH_STX;
      PH_STX:   if (last) nx = PH_SRX;
      PH_SRX:   if (last) nx = (mode == MODE_AUTO) ? PH_LTX : PH_IDLE;
      default:  nx = PH_IDLE;
    endcase
    if (abort) nx = PH_IDLE;
  end

  // length of the phase being entered; zero counts as one cycle
  always_comb begin
    unique case (nx)
      PH_LTX:   raw = cfg_long_tx;
      PH_LRX:   raw = cfg_long_rx;
      PH_GUARD: raw = cfg_guard;
      PH_STX:   raw = cfg_short_tx;
      PH_SRX:   raw = cfg_short_rx;
      default:  raw = '0;
    endcase
    ld = (raw == '0) ? '0 : raw - 1'b1;
  end

  assign cycle_end = (st == PH_SRX) && last && !abort;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= PH_IDLE;
      tmr       <= '0;
      start_stb <= 1'b0;
      long_sel  <= 1'b0;
      busy      <= 1'b0;
    end else begin
      st        <= nx;
      if (nx != st)      tmr <= ld;
      else if (!last)    tmr <= tmr - 1'b1;
      start_stb <= (nx == PH_LTX) && (st != PH_LTX);
      long_sel  <= (nx == PH_LTX) || (nx == PH_LRX);
      busy      <= (nx != PH_IDLE);
    end
  end

endmodule

// File: rtl/wrap_counter.sv
module wrap_counter #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic [W-1:0] limit,
  output logic [W-1:0] cnt,
  output logic         wrap
);

  localparam int WX = W + 1;

  logic [WX-1:0] nxt;

  assign nxt  = {1'b0, cnt} + WX'(1);
  assign wrap = inc && (nxt >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (inc)  cnt <= wrap ? '0 : nxt[W-1:0];
  end

endmodule

// File: rtl/scan_counters.sv
module scan_counters
  import chirp_seq_pkg::*;
#(
  parameter int CNT_W      = 6,
  parameter int ELEV_STEPS = 32,
  parameter int AZ_STEPS   = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic [CNT_W-1:0] cfg_chirps_per_elev,
  output logic [CNT_W-1:0] chirp_cnt,
  output logic [CNT_W-1:0] elev_cnt,
  output logic [CNT_W-1:0] azim_cnt,
  output logic             elev_stb,
  output logic             azim_stb,
  output logic             scan_done
);

  logic [CNT_W-1:0]      lim [NUM_LEVELS];
  logic [CNT_W-1:0]      cnt [NUM_LEVELS];
  logic [NUM_LEVELS-1:0] inc, wrp;

  assign lim[0] = cfg_chirps_per_elev;
  assign lim[1] = CNT_W'(ELEV_STEPS);
  assign lim[2] = CNT_W'(AZ_STEPS);

  genvar g;
  generate
    for (g = 0; g < NUM_LEVELS; g++) begin : g_lvl
      if (g == 0) begin : g_base
        assign inc[g] = adv;
      end else begin : g_chain
        assign inc[g] = wrp[g-1];
      end
      wrap_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .inc   (inc[g]),
        .limit (lim[g]),
        .cnt   (cnt[g]),
        .wrap  (wrp[g])
      );
    end
  endgenerate

  assign chirp_cnt = cnt[0];
  assign elev_cnt  = cnt[1];
  assign azim_cnt  = cnt[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      elev_stb  <= 1'b0;
      azim_stb  <= 1'b0;
      scan_done <= 1'b0;
    end else begin
      elev_stb  <= wrp[0];
      azim_stb  <= wrp[1];
      scan_done <= wrp[2];
    end
  end

endmodule

// File: rtl/chirp_sequencer.sv
module chirp_sequencer
  import chirp_seq_pkg::*;
#(
  parameter int DUR_W      = 16,
  parameter int CNT_W      = 6,
  parameter int ELEV_STEPS = 32,
  parameter int AZ_STEPS   = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic             trig,
  input  logic             ext_chirp,
  input  logic             ext_elev,
  input  logic             ext_azim,
  input  logic [DUR_W-1:0] cfg_long_tx,
  input  logic [DUR_W-1:0] cfg_long_rx,
  input  logic [DUR_W-1:0] cfg_guard,
  input  logic [DUR_W-1:0] cfg_short_tx,
  input  logic [DUR_W-1:0] cfg_short_rx,
  input  logic [CNT_W-1:0] cfg_chirps_per_elev,
  output logic             long_sel,
  output logic             chirp_stb,
  output logic             elev_stb,
  output logic             azim_stb,
  output logic [CNT_W-1:0] chirp_cnt,
  output logic [CNT_W-1:0] elev_cnt,
  output logic [CNT_W-1:0] azim_cnt,
  output logic             scanning,
  output logic             scan_done
);

  logic fsm_start, fsm_end;
  logic ctr_elev, ctr_azim;
  logic ext_chirp_q, ext_elev_q, ext_azim_q;
  logic pass;

  assign pass = (mode == MODE_EXT);

  chirp_phase_fsm #(.DUR_W(DUR_W)) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .mode         (mode),
    .trig         (trig),
    .cfg_long_tx  (cfg_long_tx),
    .cfg_long_rx  (cfg_long_rx),
    .cfg_guard    (cfg_guard),
    .cfg_short_tx (cfg_short_tx),
    .cfg_short_rx (cfg_short_rx),
    .start_stb    (fsm_start),
    .long_sel     (long_sel),
    .busy         (scanning),
    .cycle_end    (fsm_end)
  );

  scan_counters #(
    .CNT_W      (CNT_W),
    .ELEV_STEPS (ELEV_STEPS),
    .AZ_STEPS   (AZ_STEPS)
  ) u_ctr (
    .clk                 (clk),
    .rst                 (rst),
    .adv                 (fsm_end),
    .cfg_chirps_per_elev (cfg_chirps_per_elev),
    .chirp_cnt           (chirp_cnt),
    .elev_cnt            (elev_cnt),
    .azim_cnt            (azim_cnt),
    .elev_stb            (ctr_elev),
    .azim_stb            (ctr_azim),
    .scan_done           (scan_done)
  );

  // external strobes pass only in external mode; the generated ones
  // need a running mode, so the two sources never overlap
  always_ff @(posedge clk) begin
    if (rst) begin
      ext_chirp_q <= 1'b0;
      ext_elev_q  <= 1'b0;
      ext_azim_q  <= 1'b0;
    end else begin
      ext_chirp_q <= pass && ext_chirp;
      ext_elev_q  <= pass && ext_elev;
      ext_azim_q  <= pass && ext_azim;
    end
  end

  assign chirp_stb = ext_chirp_q | fsm_start;
  assign elev_stb  = ext_elev_q  | ctr_elev;
  assign azim_stb  = ext_azim_q  | ctr_azim;

endmodule

// File: rtl/chirp_sequencer_chk.sv
module chirp_sequencer_chk #(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       mode,
  input logic             long_sel,
  input logic             chirp_stb,
  input logic             elev_stb,
  input logic             azim_stb,
  input logic [CNT_W-1:0] chirp_cnt,
  input logic [CNT_W-1:0] elev_cnt,
  input logic [CNT_W-1:0] azim_cnt,
  input logic             scanning,
  input logic             scan_done
);

  a_r3_long_inside_cycle: assert property (@(posedge clk) disable iff (rst)
    long_sel |-> scanning);

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (chirp_stb && scanning && (mode == 2'b01 || mode == 2'b10)) |=> !chirp_stb);

  a_r7_chirp_step: assert property (@(posedge clk) disable iff (rst)
    !$stable(chirp_cnt) |-> (chirp_cnt == '0 || chirp_cnt == $past(chirp_cnt) + 1'b1));

  a_r8_scan_boundary: assert property (@(posedge clk) disable iff (rst)
    scan_done |-> (elev_stb && azim_stb && chirp_cnt == '0 &&
                   elev_cnt == '0 && azim_cnt == '0));

  a_r10_abort: assert property (@(posedge clk) disable iff (rst)
    (scanning && (mode == 2'b00 || mode == 2'b11)) |=> !scanning);

endmodule

bind chirp_sequencer chirp_sequencer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mode      (mode),
  .long_sel  (long_sel),
  .chirp_stb (chirp_stb),
  .elev_stb  (elev_stb),
  .azim_stb  (azim_stb),
  .chirp_cnt (chirp_cnt),
  .elev_cnt  (elev_cnt),
  .azim_cnt  (azim_cnt),
  .scanning  (scanning),
  .scan_done (scan_done)
);

// File: tb/chirp_sequencer_bench.sv
`timescale 1ns / 1ps
module chirp_sequencer_bench;

  localparam int ELEV = 3;
  localparam int AZ   = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode = 2'b00;
  logic        trig = 1'b0, ext_chirp = 1'b0, ext_elev = 1'b0, ext_azim = 1'b0;
  logic [15:0] c_ltx = 16'd1, c_lrx = 16'd1, c_g = 16'd1, c_stx = 16'd1, c_srx = 16'd1;
  logic [5:0]  c_cpe = 6'd2;
  logic        long_sel, chirp_stb, elev_stb, azim_stb, scanning, scan_done;
  logic [5:0]  chirp_cnt, elev_cnt, azim_cnt;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  int mc = 0, me = 0, ma = 0;
  bit m_elev = 1'b0;

  always #2 clk = ~clk;

  chirp_sequencer #(.ELEV_STEPS(ELEV), .AZ_STEPS(AZ)) u_chirp_sequencer (
    .clk(clk), .rst(rst), .mode(mode), .trig(trig),
    .ext_chirp(ext_chirp), .ext_elev(ext_elev), .ext_azim(ext_azim),
    .cfg_long_tx(c_ltx), .cfg_long_rx(c_lrx), .cfg_guard(c_g),
    .cfg_short_tx(c_stx), .cfg_short_rx(c_srx), .cfg_chirps_per_elev(c_cpe),
    .long_sel(long_sel), .chirp_stb(chirp_stb), .elev_stb(elev_stb),
    .azim_stb(azim_stb), .chirp_cnt(chirp_cnt), .elev_cnt(elev_cnt),
    .azim_cnt(azim_cnt), .scanning(scanning), .scan_done(scan_done)
  );

  // fields: long_tx, long_rx, guard, short_tx, short_rx, expected total, expected long
  localparam int NV = 6;
  localparam logic [15:0] VEC [NV][7] = '{
    '{16'd3,  16'd2,  16'd1,  16'd2,  16'd4,  16'd12, 16'd5},
    '{16'd0,  16'd0,  16'd0,  16'd0,  16'd0,  16'd5,  16'd2},
    '{16'd1,  16'd1,  16'd1,  16'd1,  16'd1,  16'd5,  16'd2},
    '{16'd7,  16'd0,  16'd3,  16'd0,  16'd5,  16'd17, 16'd8},
    '{16'd2,  16'd9,  16'd2,  16'd6,  16'd3,  16'd22, 16'd11},
    '{16'd16, 16'd16, 16'd16, 16'd16, 16'd16, 16'd80, 16'd32}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_adv();
    int lim;
    lim = (c_cpe == 0) ? 1 : int'(c_cpe);
    m_elev = 1'b0;
    mc++;
    if (mc >= lim) begin
      mc = 0; m_elev = 1'b1; me++;
      if (me >= ELEV) begin
        me = 0; ma++;
        if (ma >= AZ) ma = 0;
      end
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; mode = 2'b00; trig = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    mc = 0; me = 0; ma = 0;
    @(negedge clk);
  endtask

  // one single-shot chirp cycle; optional extra trigger while busy
  task automatic run_single(input int idx, input bit retrig);
    int n_scan, n_long, n_stb;
    n_scan = 0; n_long = 0; n_stb = 0;
    c_ltx = VEC[idx][0]; c_lrx = VEC[idx][1]; c_g = VEC[idx][2];
    c_stx = VEC[idx][3]; c_srx = VEC[idx][4];
    mode = 2'b10; trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    for (int k = 0; k < 400; k++) begin
      if (!scanning) break;
      n_scan++;
      if (long_sel) n_long++;
      if (chirp_stb) n_stb++;
      trig = retrig && (k == 2);
      @(negedge clk);
    end
    trig = 1'b0;
    model_adv();
    chk("R3 cycle length", n_scan, int'(VEC[idx][5]));
    chk("R3 long_sel cycles", n_long, int'(VEC[idx][6]));
    chk("R6 chirp_stb count", n_stb, 1);
    chk("R7 elev_stb at cycle end", int'(elev_stb), int'(m_elev));
    chk("R7 chirp_cnt", int'(chirp_cnt), mc);
    chk("R8 elev_cnt", int'(elev_cnt), me);
    chk("R8 azim_cnt", int'(azim_cnt), ma);
    @(negedge clk);
    chk("R5 single cycle stays idle", int'(scanning), 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int last_stb, n_stb, seen_done;
    // R1 reset state
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 scanning in reset", int'(scanning), 0);
    chk("R1 strobes in reset", int'({chirp_stb, elev_stb, azim_stb, scan_done, long_sel}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 counters after reset", int'({chirp_cnt, elev_cnt, azim_cnt}), 0);
    chk("R1 scanning after reset", int'(scanning), 0);

    // R2 external pass-through, trig ignored
    mode = 2'b00; ext_chirp = 1'b1; trig = 1'b1;
    @(negedge clk);
    ext_chirp = 1'b0; trig = 1'b0; ext_elev = 1'b1;
    chk("R2 chirp_stb follows ext", int'(chirp_stb), 1);
    chk("R2 no sequence in external mode", int'(scanning), 0);
    @(negedge clk);
    ext_elev = 1'b0; ext_azim = 1'b1;
    chk("R2 chirp_stb released", int'(chirp_stb), 0);
    chk("R2 elev_stb follows ext", int'(elev_stb), 1);
    @(negedge clk);
    ext_azim = 1'b0;
    chk("R2 azim_stb follows ext", int'(azim_stb), 1);
    chk("R2 chirp_cnt held", int'(chirp_cnt), 0);
    chk("R2 elev_cnt held", int'(elev_cnt), 0);
    @(negedge clk);
    chk("R2 trig ignored", int'(scanning), 0);

    // R3, R4, R5, R6, R7 table of single-shot cycles
    c_cpe = 6'd2;
    for (int i = 0; i < NV; i++) run_single(i, 1'b0);

    // R5 retrigger while busy has no effect
    run_single(0, 1'b1);

    // R10 abort in the last short listen cycle drops the advance
    do_reset();
    c_ltx = 3; c_lrx = 3; c_g = 3; c_stx = 3; c_srx = 3;
    mode = 2'b01;
    repeat (15) @(negedge clk);
    chk("R10 running before abort", int'(scanning), 1);
    mode = 2'b00;
    @(negedge clk);
    chk("R10 idle after abort", int'(scanning), 0);
    chk("R10 chirp_cnt not advanced", int'(chirp_cnt), 0);
    chk("R10 no elev_stb", int'(elev_stb), 0);

    // R8, R9 free-running scan with unit phases
    do_reset();
    c_ltx = 1; c_lrx = 1; c_g = 1; c_stx = 1; c_srx = 1; c_cpe = 6'd2;
    mode = 2'b01;
    @(negedge clk);
    chk("R9 first chirp on next clock", int'(chirp_stb), 1);
    last_stb = 0; n_stb = 1; seen_done = 0;
    for (int k = 1; k < 200; k++) begin
      @(negedge clk);
      if (scan_done) begin
        seen_done = 1;
        chk("R8 scan_done with chirp_stb", int'(chirp_stb), 1);
        chk("R8 scan_done with elev_stb", int'(elev_stb), 1);
        chk("R8 scan_done with azim_stb", int'(azim_stb), 1);
        chk("R8 counters zero at scan end", int'({chirp_cnt, elev_cnt, azim_cnt}), 0);
        chk("R8 chirps per scan", n_stb, 2 * ELEV * AZ);
        break;
      end
      if (chirp_stb) begin
        chk("R9 back-to-back period", k - last_stb, 5);
        last_stb = k;
        n_stb++;
      end
      chk("R9 scanning continuous", int'(scanning), 1);
    end
    chk("R8 scan_done seen", seen_done, 1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule